// File: doc/BRIEF.md
# Pair Memory Access Micro-op Sequencer

This block turns one decoded paired memory instruction into a short train of micro-ops. The instruction names two data registers, a base register and a signed immediate. It either stores the two registers to consecutive memory elements or loads the two elements into them. The elements are 64-bit or 32-bit wide. The sequencer captures the instruction on a valid/ready handshake. It then presents one micro-op at a time on a second valid/ready interface and advances to the next micro-op on each accepted handoff.

When the immediate is nonzero, the first micro-op adds it to the base register. The sum goes to a hidden temporary register that lies just above the architectural register space. The two memory micro-ops then address through that temporary register. When the immediate is zero, the add step is skipped and both memory micro-ops address through the base register directly.

Every micro-op carries the program counter of its parent instruction and an index within the train. It also carries first, last and delayed-commit flags, so that the commit stage can retire the train as one unit.

Top module: `pairseq_top`

## Requirements
- R1: `in_ready` is high only while no micro-op is pending. An accepted instruction shows `uop_valid` on the next cycle. `in_ready` stays low until the cycle after the handoff of the last micro-op.
- R2: With a nonzero immediate, micro-op 0 has opcode ADD (`uop_op`=0), reads the base register, writes the temporary register (index 2^REG_W, shown as 32 with REG_W=5), and carries the immediate as its offset.
- R3: A store pair (`in_is_load`=0) emits STORE micro-ops (`uop_op`=1). The first element names `in_rt1` with offset 0. The second names `in_rt2`. Register fields are `in_*` zero-extended by one bit.
- R4: The second element offset is 8 when `in_is_wide`=1 (64-bit elements) and 4 when `in_is_wide`=0 (32-bit elements).
- R5: A load pair (`in_is_load`=1) emits the same train with LOAD micro-ops (`uop_op`=2). These write `in_rt1` and `in_rt2` in their register field.
- R6: The memory micro-ops address through the temporary register when an add step was emitted. With a zero immediate, only the two memory micro-ops are emitted, and they address through the base register.
- R7: Only micro-op 0 has `uop_first`=1, and only the final micro-op has `uop_last`=1.
- R8: `uop_dcommit` is 1 on every micro-op except the last, where it is 0.
- R9: All micro-ops of one instruction carry the instruction's `in_pc`, and `uop_idx` counts 0, 1, 2 in emission order.
- R10: While `uop_valid` is high and `uop_ready` is low, every micro-op field holds its value.
- R11: A synchronous reset drops a partly emitted train. The next cycle shows `uop_valid`=0 and `in_ready`=1, and the next instruction starts again at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle, instruction accepted |
| in_is_load | input | 1 | 1 = load pair, 0 = store pair |
| in_is_wide | input | 1 | 1 = 64-bit elements, 0 = 32-bit |
| in_base | input | REG_W | Base register index |
| in_rt1 | input | REG_W | First data register index |
| in_rt2 | input | REG_W | Second data register index |
| in_imm | input | IMM_W | Signed byte immediate |
| in_pc | input | PC_W | Program counter of the instruction |
| uop_valid | output | 1 | Micro-op presented |
| uop_ready | input | 1 | Micro-op taken |
| uop_op | output | 2 | 0 ADD, 1 STORE, 2 LOAD |
| uop_areg | output | REG_W+1 | Address or operand register |
| uop_dreg | output | REG_W+1 | Destination, or store data register |
| uop_offset | output | IMM_W | Byte offset or add operand |
| uop_idx | output | 2 | Index within the train |
| uop_first | output | 1 | First micro-op of the train |
| uop_last | output | 1 | Last micro-op of the train |
| uop_dcommit | output | 1 | Delayed-commit flag |
| uop_pc | output | PC_W | Program counter of the parent |

## Verification
An accepted instruction's micro-op 0 is due on the cycle after the acceptance edge. Each following micro-op is due on the cycle after the edge at which its predecessor was taken. `in_ready` returns on the cycle after the last handoff. The bench drives and samples on the falling edge. It keeps its own micro-op counter, which it moves only after an edge on which it held `uop_ready` high while `uop_valid` was seen. So every presented micro-op is compared against the expected member of the train, including repeated cycles under a random stall.

// File: rtl/pairseq_pkg.sv
package pairseq_pkg;
    typedef enum logic [1:0] {
        UOP_ADD   = 2'd0,
        UOP_STORE = 2'd1,
        UOP_LOAD  = 2'd2
    } uop_op_e;

    typedef enum logic [1:0] {
        PH_ADDR  = 2'd0,
        PH_ELEM0 = 2'd1,
        PH_ELEM1 = 2'd2
    } phase_e;
endpackage

// File: rtl/pairseq_ctrl.sv
module pairseq_ctrl
    import pairseq_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int IMM_W = 12,
    parameter int PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_is_load,
    input  logic             in_is_wide,
    input  logic [REG_W-1:0] in_base,
    input  logic [REG_W-1:0] in_rt1,
    input  logic [REG_W-1:0] in_rt2,
    input  logic [IMM_W-1:0] in_imm,
    input  logic [PC_W-1:0]  in_pc,
    input  logic             fire,
    output logic             busy,
    output phase_e           phase,
    output logic             has_addr,
    output logic             is_load,
    output logic             is_wide,
    output logic [REG_W-1:0] base,
    output logic [REG_W-1:0] rt1,
    output logic [REG_W-1:0] rt2,
    output logic [IMM_W-1:0] imm,
    output logic [PC_W-1:0]  pc
);
    typedef struct packed {
        logic             busy;
        phase_e           phase;
        logic             has_addr;
        logic             is_load;
        logic             is_wide;
        logic [REG_W-1:0] base;
        logic [REG_W-1:0] rt1;
        logic [REG_W-1:0] rt2;
        logic [IMM_W-1:0] imm;
        logic [PC_W-1:0]  pc;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (in_valid) begin
                st_d.busy     = 1'b1;
                st_d.has_addr = |in_imm;
                st_d.phase    = (|in_imm) ? PH_ADDR : PH_ELEM0;
                st_d.is_load  = in_is_load;
                st_d.is_wide  = in_is_wide;
                st_d.base     = in_base;
                st_d.rt1      = in_rt1;
                st_d.rt2      = in_rt2;
                st_d.imm      = in_imm;
                st_d.pc       = in_pc;
            end
        end else if (fire) begin
            case (st_q.phase)
                PH_ADDR:  st_d.phase = PH_ELEM0;
                PH_ELEM0: st_d.phase = PH_ELEM1;
                default:  st_d.busy  = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign phase    = st_q.phase;
    assign has_addr = st_q.has_addr;
    assign is_load  = st_q.is_load;
    assign is_wide  = st_q.is_wide;
    assign base     = st_q.base;
    assign rt1      = st_q.rt1;
    assign rt2      = st_q.rt2;
    assign imm      = st_q.imm;
    assign pc       = st_q.pc;
endmodule

// File: rtl/pairseq_uopgen.sv
module pairseq_uopgen
    import pairseq_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int IMM_W = 12
) (
    input  phase_e           phase,
    input  logic             has_addr,
    input  logic             is_load,
    input  logic             is_wide,
    input  logic [REG_W-1:0] base,
    input  logic [REG_W-1:0] rt1,
    input  logic [REG_W-1:0] rt2,
    input  logic [IMM_W-1:0] imm,
    output uop_op_e          op,
    output logic [REG_W:0]   areg,
    output logic [REG_W:0]   dreg,
    output logic [IMM_W-1:0] offset,
    output logic [1:0]       idx,
    output logic             first,
    output logic             last,
    output logic             dcommit
);
    localparam logic [REG_W:0]   TMP_REG   = {1'b1, {REG_W{1'b0}}};
    localparam logic [IMM_W-1:0] WIDE_STEP = IMM_W'(8);
    localparam logic [IMM_W-1:0] NARW_STEP = IMM_W'(4);

    logic [REG_W:0] mem_base;

    always_comb begin
        mem_base = has_addr ? TMP_REG : {1'b0, base};
        op       = is_load ? UOP_LOAD : UOP_STORE;
        areg     = mem_base;
        dreg     = {1'b0, rt1};
        offset   = '0;
        case (phase)
            PH_ADDR: begin
                op     = UOP_ADD;
                areg   = {1'b0, base};
                dreg   = TMP_REG;
                offset = imm;
            end
            PH_ELEM0: begin
                dreg   = {1'b0, rt1};
                offset = '0;
            end
            default: begin
                dreg   = {1'b0, rt2};
                offset = is_wide ? WIDE_STEP : NARW_STEP;
            end
        endcase
        idx     = has_addr ? phase : (phase - 2'd1);
        first   = has_addr ? (phase == PH_ADDR) : (phase == PH_ELEM0);
        last    = (phase == PH_ELEM1);
        dcommit = (phase != PH_ELEM1);
    end
endmodule

// File: rtl/pairseq_top.sv
module pairseq_top
    import pairseq_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int IMM_W = 12,
    parameter int PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_is_load,
    input  logic             in_is_wide,
    input  logic [REG_W-1:0] in_base,
    input  logic [REG_W-1:0] in_rt1,
    input  logic [REG_W-1:0] in_rt2,
    input  logic [IMM_W-1:0] in_imm,
    input  logic [PC_W-1:0]  in_pc,
    output logic             uop_valid,
    input  logic             uop_ready,
    output logic [1:0]       uop_op,
    output logic [REG_W:0]   uop_areg,
    output logic [REG_W:0]   uop_dreg,
    output logic [IMM_W-1:0] uop_offset,
    output logic [1:0]       uop_idx,
    output logic             uop_first,
    output logic             uop_last,
    output logic             uop_dcommit,
    output logic [PC_W-1:0]  uop_pc
);
    logic             busy, has_addr, is_load, is_wide;
    phase_e           phase;
    logic [REG_W-1:0] base, rt1, rt2;
    logic [IMM_W-1:0] imm;
    uop_op_e          op;

    pairseq_ctrl #(.REG_W(REG_W), .IMM_W(IMM_W), .PC_W(PC_W)) u_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_is_load(in_is_load), .in_is_wide(in_is_wide),
        .in_base(in_base), .in_rt1(in_rt1), .in_rt2(in_rt2),
        .in_imm(in_imm), .in_pc(in_pc),
        .fire(uop_valid & uop_ready),
        .busy(busy), .phase(phase), .has_addr(has_addr),
        .is_load(is_load), .is_wide(is_wide),
        .base(base), .rt1(rt1), .rt2(rt2), .imm(imm), .pc(uop_pc)
    );

    pairseq_uopgen #(.REG_W(REG_W), .IMM_W(IMM_W)) u_gen (
        .phase(phase), .has_addr(has_addr), .is_load(is_load),
        .is_wide(is_wide), .base(base), .rt1(rt1), .rt2(rt2), .imm(imm),
        .op(op), .areg(uop_areg), .dreg(uop_dreg), .offset(uop_offset),
        .idx(uop_idx), .first(uop_first), .last(uop_last),
        .dcommit(uop_dcommit)
    );

    assign in_ready  = ~busy;
    assign uop_valid = busy;
    assign uop_op    = op;
endmodule

// File: rtl/pairseq_chk.sv
module pairseq_chk #(
    parameter int REG_W = 5,
    parameter int IMM_W = 12,
    parameter int PC_W  = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             uop_valid,
    input logic             uop_ready,
    input logic [1:0]       uop_op,
    input logic [REG_W:0]   uop_areg,
    input logic [REG_W:0]   uop_dreg,
    input logic [IMM_W-1:0] uop_offset,
    input logic [1:0]       uop_idx,
    input logic             uop_first,
    input logic             uop_last,
    input logic             uop_dcommit,
    input logic [PC_W-1:0]  uop_pc
);
    localparam logic [REG_W:0] TMP_REG = {1'b1, {REG_W{1'b0}}};

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !uop_valid); // R1
    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> uop_valid); // R1
    AST_LAST_FREES: assert property (@(posedge clk) disable iff (rst)
        uop_valid && uop_ready && uop_last |=> in_ready); // R1
    AST_ADD_TO_TMP: assert property (@(posedge clk) disable iff (rst)
        uop_valid && uop_op == 2'd0 |-> uop_dreg == TMP_REG && uop_first); // R2
    AST_FIRST_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        uop_valid && uop_first |-> uop_idx == 2'd0); // R7
    AST_DCOMMIT_NOT_LAST: assert property (@(posedge clk) disable iff (rst)
        uop_valid |-> uop_dcommit != uop_last); // R8
    AST_NEXT_INDEX: assert property (@(posedge clk) disable iff (rst)
        uop_valid && uop_ready && !uop_last |=>
            uop_valid && uop_idx == $past(uop_idx) + 2'd1 && $stable(uop_pc)); // R9
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        uop_valid && !uop_ready |=> uop_valid && $stable(uop_op) &&
            $stable(uop_areg) && $stable(uop_dreg) && $stable(uop_offset) &&
            $stable(uop_idx) && $stable(uop_pc)); // R10
endmodule

bind pairseq_top pairseq_chk #(.REG_W(REG_W), .IMM_W(IMM_W), .PC_W(PC_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_op(uop_op),
    .uop_areg(uop_areg), .uop_dreg(uop_dreg), .uop_offset(uop_offset),
    .uop_idx(uop_idx), .uop_first(uop_first), .uop_last(uop_last),
    .uop_dcommit(uop_dcommit), .uop_pc(uop_pc)
);

// File: tb/pairseq_top_bench.sv
`timescale 1ns/1ps
module pairseq_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_is_load = 1'b0, in_is_wide = 1'b0;
    logic [4:0]  in_base = '0, in_rt1 = '0, in_rt2 = '0;
    logic [11:0] in_imm = '0;
    logic [31:0] in_pc = '0;
    logic        uop_ready = 1'b0;
    logic        in_ready, uop_valid, uop_first, uop_last, uop_dcommit;
    logic [1:0]  uop_op, uop_idx;
    logic [5:0]  uop_areg, uop_dreg;
    logic [11:0] uop_offset;
    logic [31:0] uop_pc;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pairseq_top u_pairseq_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_is_load(in_is_load), .in_is_wide(in_is_wide), .in_base(in_base),
        .in_rt1(in_rt1), .in_rt2(in_rt2), .in_imm(in_imm), .in_pc(in_pc),
        .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_op(uop_op),
        .uop_areg(uop_areg), .uop_dreg(uop_dreg), .uop_offset(uop_offset),
        .uop_idx(uop_idx), .uop_first(uop_first), .uop_last(uop_last),
        .uop_dcommit(uop_dcommit), .uop_pc(uop_pc)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void exp_uop(input bit ld, input bit wide, input logic [4:0] base,
            input logic [4:0] r1, input logic [4:0] r2, input logic [11:0] imm, input int k,
            output logic [1:0] op, output logic [5:0] ar, output logic [5:0] dr,
            output logic [11:0] off, output logic [2:0] flags);
        bit ha = (imm != 0);
        int n  = ha ? 3 : 2;
        int m  = ha ? k - 1 : k;
        if (m < 0) begin
            op = 2'd0; ar = {1'b0, base}; dr = 6'd32; off = imm;
        end else begin
            op  = ld ? 2'd2 : 2'd1;
            ar  = ha ? 6'd32 : {1'b0, base};
            dr  = (m == 0) ? {1'b0, r1} : {1'b0, r2};
            off = (m == 0) ? 12'd0 : (wide ? 12'd8 : 12'd4);
        end
        flags = {k == 0, k == n - 1, k != n - 1};
    endfunction

    task automatic run_instr(input bit ld, input bit wide, input logic [4:0] base,
            input logic [4:0] r1, input logic [4:0] r2, input logic [11:0] imm,
            input logic [31:0] pc, input int stall_pct, input int stop_after);
        int n = (imm != 0) ? 3 : 2;
        int k = 0;
        logic [1:0] eop; logic [5:0] ear, edr; logic [11:0] eoff; logic [2:0] efl;
        string rq;
        rq = (imm == 0) ? (ld ? "R5 R6" : "R3 R6") : (ld ? "R2 R5" : "R2 R3");
        @(negedge clk);
        check("R1 ready when idle", in_ready, 1);
        in_valid = 1; in_is_load = ld; in_is_wide = wide; in_base = base;
        in_rt1 = r1; in_rt2 = r2; in_imm = imm; in_pc = pc;
        @(posedge clk);
        @(negedge clk);
        in_valid = 0;
        in_base = ~base; in_rt1 = ~r1; in_imm = ~imm; in_pc = ~pc;
        while (k < n && k < stop_after) begin
            uop_ready = ($urandom % 100) >= stall_pct;
            exp_uop(ld, wide, base, r1, r2, imm, k, eop, ear, edr, eoff, efl);
            check("R1 uop valid while busy", uop_valid, 1);
            check("R1 in_ready low while busy", in_ready, 0);
            check({rq, " op/regs"}, {uop_op, uop_areg, uop_dreg}, {eop, ear, edr});
            check(wide ? "R4 offset wide" : "R4 offset narrow", uop_offset, eoff);
            check("R7 R8 flags", {uop_first, uop_last, uop_dcommit}, efl);
            check("R9 idx/pc", {uop_idx, uop_pc}, {k[1:0], pc});
            @(posedge clk);
            if (uop_ready) k++;
            @(negedge clk);
            if (!uop_ready) check("R10 stalled uop held", {uop_op, uop_dreg, uop_offset, uop_idx},
                                  {eop, edr, eoff, k[1:0]});
        end
        uop_ready = 0;
        if (k == n) begin
            check("R1 idle after last", {uop_valid, in_ready}, 2'b01);
        end
    endtask

    initial begin
        void'($urandom(32'h1E5EED));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 reset state", {uop_valid, in_ready}, 2'b01);
        rst = 0;
        run_instr(0, 1, 5'd0, 5'd1, 5'd2, 12'd16, 32'h0040_006C, 0, 9);
        run_instr(0, 0, 5'd3, 5'd4, 5'd5, 12'd0, 32'h0040_0070, 0, 9);
        run_instr(1, 1, 5'd7, 5'd8, 5'd9, 12'hFF8, 32'h0040_0074, 50, 9);
        run_instr(1, 0, 5'd31, 5'd30, 5'd29, 12'h800, 32'h0040_0078, 50, 9);
        run_instr(1, 1, 5'd6, 5'd10, 5'd11, 12'd0, 32'h0040_007C, 30, 9);
        run_instr(0, 0, 5'd12, 5'd13, 5'd14, 12'h7FF, 32'h0040_0080, 30, 9);
        // R11: abort after one handoff
        run_instr(0, 1, 5'd1, 5'd2, 5'd3, 12'd24, 32'h0000_1000, 0, 1);
        @(negedge clk);
        rst = 1;
        @(posedge clk);
        @(negedge clk);
        check("R11 reset drops train", {uop_valid, in_ready}, 2'b01);
        rst = 0;
        run_instr(1, 0, 5'd4, 5'd5, 5'd6, 12'd0, 32'h0000_2000, 0, 9);
        for (int i = 0; i < 60; i++) begin
            logic [11:0] im;
            im = ($urandom % 4 == 0) ? 12'd0 : 12'($urandom);
            run_instr(1'($urandom), 1'($urandom), 5'($urandom), 5'($urandom),
                      5'($urandom), im, $urandom, 25, 9);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule